// File: doc/BRIEF.md
# External Interrupt Request Router

This block watches sixteen external request pins and turns each rising edge on them into a request. Every pin passes through a two-flop synchronizer and an edge detector. A detected edge sets a sticky status flag for that pin. Each pin also has an enable bit. A pin whose flag and enable are both set raises a request.

For pins 2 to 15, the request always goes to a single CPU interrupt line. Pins 0 and 1 each have a route bit. That bit sends the pin's request either to the interrupt line or to a dedicated DMA request line for that pin. The flags, enables and route bits are reached through a simple 32-bit register bus. Software clears a flag by writing a one to its bit. A DMA engine clears a flag with a one-cycle completion pulse on its own input.

Reset is asynchronous and active low on `rst_n`. It is released in step with the clock through a two-flop reset synchronizer inside the block.

Top module: `ext_irq_router`

## Requirements
- R1: After reset, the flag, enable and route registers all read 0, and `irq_out` and `dma_req` are low.
- R2: A rising edge on `irq_pin[n]` sets flag bit n (bit n of the word at offset 0x14) within four clock cycles. The flag stays set after the pin falls. A pin that stays high does not set the flag again once it has been cleared.
- R3: A bus write to offset 0x14 clears every flag whose bit is 1 in `bus_wdata[15:0]`. Bits written as 0 leave their flags unchanged.
- R4: Offset 0x18 holds sixteen read/write enable bits in `bus_wdata[15:0]`, with bit n enabling pin n. Bits 31:16 read as 0 whatever was written to them.
- R5: Offset 0x1C holds two read/write route bits in `bus_wdata[1:0]`, with bit i for pin i. Bits 31:2 ignore writes and read as 0.
- R6: `irq_out` is high exactly when some pin n has its flag and enable set and is either n ≥ 2 or has route bit n at 0.
- R7: `dma_req[i]`, for i in {0,1}, is high exactly when pin i has its flag, its enable and its route bit all set.
- R8: A pulse on `dma_done[i]` clears flag i, and with it the request that flag was holding.
- R9: A read at an offset other than 0x14, 0x18 or 0x1C returns 0. `bus_rdata` is 0 while `bus_sel` is low.
- R10: If an edge on pin n and a clear of flag n happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 16 | External request pins, asynchronous to clk |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dma_done | input | 2 | Completion pulses that clear flags 1:0 |
| irq_out | output | 1 | Combined CPU interrupt request |
| dma_req | output | 2 | DMA requests for pins 1:0, held while active |

## Verification
The in-RTL assertions check on every cycle that a detected edge always lands in its flag, that a flag only falls when it is cleared, that a write-one clear takes effect on the next cycle, and that the route bits move only on a bus write to their offset. Only the bench scenarios can show how the route bits and enables combine into `irq_out` and `dma_req`, and that the synchronizer latency fits inside the stated window. The same goes for the behaviours seen through the bus: read-back masking, the zero word at unmapped offsets, a pin held high not re-triggering after a clear, and a set winning over a clear in the same cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADR_W  = 8;
  localparam logic [ADR_W-1:0] OFS_FLAG  = 8'h14;
  localparam logic [ADR_W-1:0] OFS_EN    = 8'h18;
  localparam logic [ADR_W-1:0] OFS_ROUTE = 8'h1C;
endpackage

// File: rtl/eirq_sync_edge.sv
module eirq_sync_edge #(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] rise_o
);
  for (genvar n = 0; n < N_PINS; n++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[n];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise_o[n] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned N_DMA  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] rise_i,
  input  logic [N_DMA-1:0]  done_i,
  output logic [N_PINS-1:0] flag_q,
  output logic [N_PINS-1:0] en_q,
  output logic [N_DMA-1:0]  route_q
);
  localparam int unsigned PAD_P = BUS_W - N_PINS;
  localparam int unsigned PAD_D = BUS_W - N_DMA;
  localparam int unsigned PAD_C = N_PINS - N_DMA;

  logic              wr_flag, wr_en, wr_route;
  logic [N_PINS-1:0] clr, flag_d, en_d;
  logic [N_DMA-1:0]  route_d;
  logic              flag_ce;

  always_comb begin
    wr_flag  = bus_sel & bus_wr & (bus_addr == OFS_FLAG);
    wr_en    = bus_sel & bus_wr & (bus_addr == OFS_EN);
    wr_route = bus_sel & bus_wr & (bus_addr == OFS_ROUTE);
    clr      = {{PAD_C{1'b0}}, done_i};
    if (wr_flag) clr = clr | bus_wdata[N_PINS-1:0];
    flag_d   = (flag_q & ~clr) | rise_i;
    flag_ce  = (|clr) | (|rise_i);
    en_d     = bus_wdata[N_PINS-1:0];
    route_d  = bus_wdata[N_DMA-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (flag_ce)  flag_q  <= flag_d;
      if (wr_en)    en_q    <= en_d;
      if (wr_route) route_q <= route_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        OFS_FLAG:  bus_rdata = {{PAD_P{1'b0}}, flag_q};
        OFS_EN:    bus_rdata = {{PAD_P{1'b0}}, en_q};
        OFS_ROUTE: bus_rdata = {{PAD_D{1'b0}}, route_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R2
  edge_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((flag_q & $past(rise_i)) == $past(rise_i)));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~clr)) |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && ((bus_wdata[N_PINS-1:0] & rise_i) == '0))
      |=> ((flag_q & $past(bus_wdata[N_PINS-1:0])) == '0));

  // R5
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_route |=> $stable(route_q));
endmodule

// File: rtl/eirq_route.sv
module eirq_route #(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned N_DMA  = 2
) (
  input  logic [N_PINS-1:0] flag_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_DMA-1:0]  route_i,
  output logic              irq_o,
  output logic [N_DMA-1:0]  dma_o
);
  logic [N_PINS-1:0] irq_vec;

  for (genvar n = 0; n < N_PINS; n++) begin : g_rt
    if (n < N_DMA) begin : g_sel
      assign irq_vec[n] = flag_i[n] & en_i[n] & ~route_i[n];
      assign dma_o[n]   = flag_i[n] & en_i[n] &  route_i[n];
    end else begin : g_fix
      assign irq_vec[n] = flag_i[n] & en_i[n];
    end
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import eirq_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned N_DMA  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_DMA-1:0]  dma_done,
  output logic              irq_out,
  output logic [N_DMA-1:0]  dma_req
);
  logic              rst_s1_q, rst_s2_q;
  logic [N_PINS-1:0] rise, flag, en;
  logic [N_DMA-1:0]  route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  eirq_sync_edge #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_s2_q), .pin_i(irq_pin), .rise_o(rise));

  eirq_regs #(.N_PINS(N_PINS), .N_DMA(N_DMA)) u_regs (
    .clk(clk), .rst_n(rst_s2_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rise_i(rise), .done_i(dma_done), .flag_q(flag), .en_q(en),
    .route_q(route));

  eirq_route #(.N_PINS(N_PINS), .N_DMA(N_DMA)) u_route (
    .flag_i(flag), .en_i(en), .route_i(route), .irq_o(irq_out),
    .dma_o(dma_req));
endmodule

// File: tb/ext_irq_router_bench.sv
module ext_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_pin;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  dma_done, dma_req;
  logic        irq_out;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_router u_ext_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_done(dma_done), .irq_out(irq_out),
    .dma_req(dma_req));

  // fields: [36:21] pins, [20:5] enable, [4:3] route, [2] irq, [1:0] dma
  localparam logic [36:0] VEC [7] = '{
    {16'h0001, 16'h0001, 2'b00, 1'b1, 2'b00},
    {16'h0001, 16'h0001, 2'b01, 1'b0, 2'b01},
    {16'h0003, 16'h0003, 2'b11, 1'b0, 2'b11},
    {16'h0003, 16'h0003, 2'b10, 1'b1, 2'b10},
    {16'h8000, 16'h0000, 2'b00, 1'b0, 2'b00},
    {16'h8004, 16'h0004, 2'b11, 1'b1, 2'b00},
    {16'h0002, 16'h0001, 2'b10, 1'b0, 2'b00}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk); irq_pin = p;
    repeat (4) @(negedge clk);
    irq_pin = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; irq_pin = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; dma_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h14, r); chk(r, 0, "R1 flags");
    rd(8'h18, r); chk(r, 0, "R1 enable");
    rd(8'h1C, r); chk(r, 0, "R1 route");
    chk({29'd0, irq_out, dma_req}, 0, "R1 outputs");

    // R6 R7 vector walk, R2 flag capture
    foreach (VEC[i]) begin
      wr(8'h14, 32'hFFFF);
      wr(8'h18, {16'h0, VEC[i][20:5]});
      wr(8'h1C, {30'h0, VEC[i][4:3]});
      pulse(VEC[i][36:21]);
      rd(8'h14, r); chk(r, {16'h0, VEC[i][36:21]}, "R2 flag set");
      chk({31'd0, irq_out}, {31'd0, VEC[i][2]}, "R6 irq_out");
      chk({30'd0, dma_req}, {30'd0, VEC[i][1:0]}, "R7 dma_req");
    end

    // R3 write zero keeps, write one clears
    wr(8'h14, 32'h0000);
    rd(8'h14, r); chk(r, 32'h0002, "R3 zero write");
    wr(8'h14, 32'h0002);
    rd(8'h14, r); chk(r, 0, "R3 w1c");

    // R4 upper bits masked
    wr(8'h18, 32'hFFFF_A5A5);
    rd(8'h18, r); chk(r, 32'h0000_A5A5, "R4 enable readback");

    // R5 route reserved bits
    wr(8'h1C, 32'hFFFF_FFFE);
    rd(8'h1C, r); chk(r, 32'h2, "R5 route readback");

    // R8 dma_done clears flag 1
    wr(8'h18, 32'h3);
    wr(8'h1C, 32'h3);
    pulse(16'h0003);
    chk({30'd0, dma_req}, 32'h3, "R8 pre");
    @(negedge clk); dma_done = 2'b10;
    @(negedge clk); dma_done = 2'b00;
    chk({30'd0, dma_req}, 32'h1, "R8 dma_req after done");
    rd(8'h14, r); chk(r, 32'h1, "R8 flag after done");

    // R2 held-high pin does not retrigger
    wr(8'h14, 32'hFFFF);
    @(negedge clk); irq_pin = 16'h0010;
    repeat (5) @(negedge clk);
    wr(8'h14, 32'h0010);
    repeat (5) @(negedge clk);
    rd(8'h14, r); chk(r, 0, "R2 level no retrigger");
    irq_pin = '0;
    repeat (4) @(negedge clk);

    // R10 set wins over clear: flag 5 already set, new edge lands with clear
    pulse(16'h0020);
    @(negedge clk); irq_pin = 16'h0020; // sync1 at next edge k
    @(negedge clk);                     // after k
    @(negedge clk);                     // after k+1, rise visible
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h20;
    @(negedge clk);                     // after k+2
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h14, r); chk(r, 32'h20, "R10 set over clear");
    irq_pin = '0;

    // R9 unmapped and deselected reads
    rd(8'h10, r); chk(r, 0, "R9 unmapped 0x10");
    rd(8'h20, r); chk(r, 0, "R9 unmapped 0x20");
    @(negedge clk); bus_addr = 8'h18; bus_sel = 1'b0;
    #1 chk(bus_rdata, 0, "R9 deselected");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h14, r); chk(r, 0, "R1 flags after reset");
    rd(8'h18, r); chk(r, 0, "R1 enable after reset");
    chk({29'd0, irq_out, dma_req}, 0, "R1 outputs after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule